// File: doc/BRIEF.md
# Batch Event Capture Buffer with Trigger Veto

The block stores fixed-length trigger events in a word-addressed on-chip memory. When a trigger is accepted, the block takes the data input word on that cycle and on each cycle after it until the event length is reached. All of those words form one event. Two event lengths exist: a normal length and a longer one. The `long_mode_i` input selects between them, and its value is taken when the trigger is accepted. Events are packed back to back from address zero.

The buffer works in whole batches and does not behave as a streaming FIFO. When the free space can no longer hold a whole event of the selected length, `busy_o` goes high. While `busy_o` is high every trigger is refused and counted. The stored words are then drained in write order through a valid/ready port, and a flag marks the last word of each event. One cycle after the final word is taken, the buffer is empty again and `busy_o` is released. A trigger that arrives while an event is still being written is ignored, flagged and counted. Both error counters saturate and keep their values across drains.

Top module: `evcap_buf`

## Requirements
- R1: A trigger seen while `busy_o` is low and no event is being written is accepted. `din_i` is stored on the trigger cycle and on each following cycle until the event length is reached. `evt_count_o` goes up by one on the clock edge that stores the final word.
- R2: The event length is LEN_SHORT words (default 5) when `long_mode_i`=0 at acceptance, and LEN_LONG words (default 12) when it is 1. A later change of `long_mode_i` does not alter an event already being written.
- R3: A trigger on any cycle after the first word of an event is being written adds no word and starts no event. `ovl_err_o` is high in that same cycle, and `ovl_cnt_o` goes up by one at the next edge.
- R4: `busy_o` goes high in any cycle with no event being written in which the free words (DEPTH minus stored words) are fewer than the length chosen by the present `long_mode_i`. After that it stays high until the drain completes, whatever `long_mode_i` does.
- R5: A trigger while `busy_o` is high stores nothing, and `veto_cnt_o` goes up by one.
- R6: While `busy_o` is latched, `rd_valid_o` is high and `rd_data_o` shows the stored words in write order. A word advances only on a cycle with `rd_ready_i`=1, and it stays stable otherwise. `rd_valid_o` is low whenever `busy_o` is low.
- R7: `rd_last_o` is 1 on the final word of each event and 0 on every other word.
- R8: On the cycle after the handshake of the final stored word, `busy_o`, `rd_valid_o` and `evt_count_o` are all 0. The next event is stored from address zero.
- R9: `veto_cnt_o` and `ovl_cnt_o` stop at their all-ones value and are not cleared by a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger request, one cycle per trigger |
| long_mode_i | input | 1 | 1 selects the long event length |
| din_i | input | WORD_W | Event data word |
| busy_o | output | 1 | Buffer cannot take an event; triggers are vetoed |
| ovl_err_o | output | 1 | Trigger arrived while an event was being written |
| rd_valid_o | output | 1 | Drain word available |
| rd_ready_i | input | 1 | Host takes the drain word |
| rd_data_o | output | WORD_W | Drain word |
| rd_last_o | output | 1 | Final word of an event |
| evt_count_o | output | ECW | Events currently stored |
| veto_cnt_o | output | CNT_W | Vetoed triggers, saturating |
| ovl_cnt_o | output | CNT_W | Overlapping triggers, saturating |

## Verification
The bench targets the boundary at which free space first falls short of an event. A design with an off-by-one here would either take an event that overruns the memory, or raise `busy_o` one event too early. The bench switches `long_mode_i` while the buffer is partly full, to check that busy latches and does not fall again when the mode goes back. Without the latch, the buffer would re-arm in the middle of a batch. The drain runs with ready gaps and must keep word order and last flags. The re-arm is checked one cycle after the final handshake: a late or missing pointer reset would leave `busy_o` high, or place the next batch at a stale address. Held triggers run back to back, and enough vetoes are applied to reach saturation. These steps expose wrong overlap accounting and counters that wrap.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic {WR_IDLE, WR_BURST} wr_state_e;

  // Event length chosen by mode.
  function automatic int unsigned ev_len(input logic long_mode,
                                         input int unsigned len_s,
                                         input int unsigned len_l);
    return long_mode ? len_l : len_s;
  endfunction

  // True when a whole event of length len still fits.
  function automatic logic room_for(input int unsigned used,
                                    input int unsigned depth,
                                    input int unsigned len);
    return (used <= depth) && ((depth - used) >= len);
  endfunction

endpackage

// File: rtl/evcap_store.sv
module evcap_store #(
  parameter int unsigned MW    = 17,
  parameter int unsigned DEPTH = 40,
  parameter int unsigned PW    = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [MW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [MW-1:0] rdata_o
);
  logic [MW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/evcap_wr.sv
module evcap_wr
  import evcap_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned LEN_SHORT = 5,
  parameter int unsigned LEN_LONG  = 12,
  parameter int unsigned DEPTH     = 40,
  parameter int unsigned PW        = 6,
  parameter int unsigned ECW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              long_mode_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              full_i,
  input  logic              drain_done_i,
  output logic              busy_o,
  output logic              arm_full_o,
  output logic              accept_o,
  output logic              ovl_o,
  output logic              veto_o,
  output logic              we_o,
  output logic [PW-1:0]     waddr_o,
  output logic [WORD_W:0]   wdata_o,
  output logic [PW-1:0]     used_o,
  output logic [ECW-1:0]    evt_count_o
);
  localparam int unsigned LW = $clog2(LEN_LONG + 1);

  wr_state_e       state_q;
  logic [LW-1:0]   rem_q;
  logic [PW-1:0]   wr_ptr_q;
  logic [ECW-1:0]  ev_cnt_q;
  logic [LW-1:0]   cur_len;
  logic            fits;
  logic            idle;
  logic            last_word;

  assign cur_len   = LW'(ev_len(long_mode_i, LEN_SHORT, LEN_LONG));
  assign fits      = room_for(32'(wr_ptr_q), DEPTH, 32'(cur_len));
  assign idle      = (state_q == WR_IDLE);
  assign arm_full_o = idle & ~fits;
  assign busy_o    = full_i | arm_full_o;
  assign accept_o  = trig_i & idle & ~busy_o;
  assign ovl_o     = trig_i & ~idle;
  assign veto_o    = trig_i & busy_o;
  assign we_o      = accept_o | ~idle;
  assign last_word = accept_o ? (cur_len == LW'(1)) : (rem_q == LW'(1));
  assign waddr_o   = wr_ptr_q;
  assign wdata_o   = {last_word, din_i};
  assign used_o    = wr_ptr_q;
  assign evt_count_o = ev_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WR_IDLE;
      rem_q    <= '0;
      wr_ptr_q <= '0;
      ev_cnt_q <= '0;
    end else if (drain_done_i) begin
      state_q  <= WR_IDLE;
      rem_q    <= '0;
      wr_ptr_q <= '0;
      ev_cnt_q <= '0;
    end else begin
      if (we_o) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (we_o && last_word) ev_cnt_q <= ev_cnt_q + ECW'(1);
      if (accept_o) begin
        rem_q   <= cur_len - LW'(1);
        state_q <= (cur_len > LW'(1)) ? WR_BURST : WR_IDLE;
      end else if (!idle) begin
        rem_q <= rem_q - LW'(1);
        if (rem_q == LW'(1)) state_q <= WR_IDLE;
      end
    end
  end

  // R4: the write pointer never passes the memory size.
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wr_ptr_q) <= DEPTH);

  // R3: an overlapping trigger does not restart the burst count.
  p_ovl_keeps_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_o && rem_q > LW'(1) |=> state_q == WR_BURST && rem_q == $past(rem_q) - LW'(1));
endmodule

// File: rtl/evcap_drain.sv
module evcap_drain #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 40,
  parameter int unsigned PW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_full_i,
  input  logic [PW-1:0]     used_i,
  input  logic              rd_ready_i,
  input  logic [WORD_W:0]   mem_q_i,
  output logic              full_o,
  output logic [PW-1:0]     raddr_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              done_o
);
  logic          full_q;
  logic [PW-1:0] rd_ptr_q;
  logic          take;

  assign full_o     = full_q;
  assign raddr_o    = rd_ptr_q;
  assign rd_valid_o = full_q;
  assign rd_data_o  = mem_q_i[WORD_W-1:0];
  assign rd_last_o  = full_q & mem_q_i[WORD_W];
  assign take       = full_q & rd_ready_i;
  assign done_o     = take & (rd_ptr_q == used_i - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      rd_ptr_q <= '0;
    end else if (done_o) begin
      full_q   <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      if (!full_q && arm_full_i) full_q <= 1'b1;
      if (take) rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  // R6: a word that is not taken stays in place.
  p_rd_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o));

  // R6: the read pointer never passes the stored words.
  p_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> rd_ptr_q < used_i);
endmodule

// File: rtl/evcap_satcnt.sv
module evcap_satcnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + CW'(1);
  end

  // R9: the counter never wraps from all-ones.
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '1 |=> cnt_q == '1);
endmodule

// File: rtl/evcap_buf.sv
module evcap_buf
  import evcap_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned LEN_SHORT = 5,
  parameter int unsigned LEN_LONG  = 12,
  parameter int unsigned EVT_CAP   = 8,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned DEPTH    = EVT_CAP * LEN_SHORT,
  localparam int unsigned PW       = $clog2(DEPTH + 1),
  localparam int unsigned ECW      = $clog2(EVT_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              long_mode_i,
  input  logic [WORD_W-1:0] din_i,
  output logic              busy_o,
  output logic              ovl_err_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic [ECW-1:0]    evt_count_o,
  output logic [CNT_W-1:0]  veto_cnt_o,
  output logic [CNT_W-1:0]  ovl_cnt_o
);
  localparam int unsigned MW = WORD_W + 1;

  logic          full_w, arm_full_w, accept_w, ovl_w, veto_w, we_w, done_w;
  logic [PW-1:0] waddr_w, raddr_w, used_w;
  logic [MW-1:0] wdata_w, rdata_w;
  logic [1:0]    inc_w;
  logic [CNT_W-1:0] cnt_w [2];

  evcap_wr #(
    .WORD_W(WORD_W), .LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG),
    .DEPTH(DEPTH), .PW(PW), .ECW(ECW)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .long_mode_i(long_mode_i),
    .din_i(din_i), .full_i(full_w), .drain_done_i(done_w),
    .busy_o(busy_o), .arm_full_o(arm_full_w), .accept_o(accept_w),
    .ovl_o(ovl_w), .veto_o(veto_w), .we_o(we_w), .waddr_o(waddr_w),
    .wdata_o(wdata_w), .used_o(used_w), .evt_count_o(evt_count_o)
  );

  evcap_store #(.MW(MW), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .we_i(we_w), .waddr_i(waddr_w), .wdata_i(wdata_w),
    .raddr_i(raddr_w), .rdata_o(rdata_w)
  );

  evcap_drain #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PW(PW)) u_drain (
    .clk(clk), .rst_n(rst_n), .arm_full_i(arm_full_w), .used_i(used_w),
    .rd_ready_i(rd_ready_i), .mem_q_i(rdata_w), .full_o(full_w),
    .raddr_o(raddr_w), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_last_o(rd_last_o), .done_o(done_w)
  );

  assign inc_w     = {ovl_w, veto_w};
  assign ovl_err_o = ovl_w;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    evcap_satcnt #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_w[g]), .cnt_o(cnt_w[g])
    );
  end

  assign veto_cnt_o = cnt_w[0];
  assign ovl_cnt_o  = cnt_w[1];

  // R4: once latched, busy holds until the drain finishes.
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_w |=> busy_o);

  // R5: nothing is written while busy.
  p_no_store_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !we_w);

  // R5: a vetoed trigger adds one to the veto counter.
  p_veto_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && busy_o && veto_cnt_o != '1 |=> veto_cnt_o == $past(veto_cnt_o) + CNT_W'(1));

  // R6: no drain word unless busy.
  p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_valid_o);

  // R8: the cycle after the last handshake the buffer is empty and open.
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_o && evt_count_o == '0 && !rd_valid_o);

  // R1: an accept is never also counted as overlap or veto.
  p_accept_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !ovl_err_o && !busy_o);
endmodule

// File: tb/evcap_buf_bench.sv
module evcap_buf_bench;
  localparam int LS = 5;
  localparam int LL = 12;
  localparam int CAP = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic long_mode = 1'b0;
  logic [15:0] din = '0;
  logic rd_ready = 1'b0;
  logic busy, ovl_err, rd_valid, rd_last;
  logic [15:0] rd_data;
  logic [3:0] evt_count;
  logic [CW-1:0] veto_cnt, ovl_cnt;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;
  logic [16:0] exp_q [$];

  always #10 clk = ~clk;

  evcap_buf #(.WORD_W(16), .LEN_SHORT(LS), .LEN_LONG(LL), .EVT_CAP(CAP), .CNT_W(CW)) u_evcap_buf (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .long_mode_i(long_mode), .din_i(din),
    .busy_o(busy), .ovl_err_o(ovl_err), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .rd_data_o(rd_data), .rd_last_o(rd_last), .evt_count_o(evt_count),
    .veto_cnt_o(veto_cnt), .ovl_cnt_o(ovl_cnt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One event; ovl_at>0 pulses a trigger on that word.
  task automatic send_event(input bit lng, input logic [15:0] base, input int ovl_at);
    int len = lng ? LL : LS;
    @(negedge clk);
    trig = 1'b1; long_mode = lng; din = base;
    #1 chk("R1", "busy at accept", 32'(busy), 0);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      trig = (k == ovl_at); din = base + 16'(k);
      if (k == ovl_at) begin
        #1 chk("R3", "ovl_err pulse", 32'(ovl_err), 1);
      end
    end
    for (int k = 0; k < len; k++) exp_q.push_back({(k == len - 1), base + 16'(k)});
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic drain_all(input int gap_mod);
    int n = exp_q.size();
    int idx = 0;
    int cyc = 0;
    while (idx < n && cyc < 4000) begin
      @(negedge clk);
      rd_ready = (gap_mod == 0) ? 1'b1 : ((cyc % gap_mod) != 1);
      #1;
      chk("R6", "rd_valid during drain", 32'(rd_valid), 1);
      if (rd_ready) begin
        chk("R6", "drain data order", 32'(rd_data), 32'(exp_q[idx][15:0]));
        chk("R7", "last flag", 32'(rd_last), 32'(exp_q[idx][16]));
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    #1;
    chk("R8", "busy released", 32'(busy), 0);
    chk("R8", "rd_valid low", 32'(rd_valid), 0);
    chk("R8", "event count cleared", 32'(evt_count), 0);
    exp_q.delete();
  endtask

  task automatic t_reset();
    #1;
    chk("R8", "reset busy", 32'(busy), 0);
    chk("R6", "reset valid", 32'(rd_valid), 0);
    chk("R1", "reset evt", 32'(evt_count), 0);
    chk("R9", "reset veto", 32'(veto_cnt), 0);
    chk("R9", "reset ovl", 32'(ovl_cnt), 0);
  endtask

  task automatic t_fill_short();
    for (int e = 0; e < CAP; e++) begin
      send_event(1'b0, 16'h100 + 16'(e * 16), (e == 2) ? 2 : 0);
      #1 chk("R1", "evt count step", 32'(evt_count), 32'(e + 1));
      if (e < CAP - 1) chk("R4", "not busy while room", 32'(busy), 0);
    end
    chk("R3", "one overlap counted", 32'(ovl_cnt), 1);
    chk("R4", "busy after last fitting event", 32'(busy), 1);
    for (int v = 0; v < 3; v++) begin
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
    end
    #1;
    chk("R5", "veto count", 32'(veto_cnt), 3);
    chk("R5", "no event on veto", 32'(evt_count), CAP);
    drain_all(3);
  endtask

  task automatic t_long();
    send_event(1'b1, 16'h800, 0);
    send_event(1'b1, 16'h900, 0);
    #1 chk("R2", "two long events fit", 32'(busy), 0);
    send_event(1'b1, 16'hA00, 0);
    #1;
    chk("R2", "long events stored", 32'(evt_count), 3);
    chk("R4", "busy with 4 free words in long mode", 32'(busy), 1);
    drain_all(0);
  endtask

  task automatic t_mode_switch();
    for (int e = 0; e < 6; e++) send_event(1'b0, 16'h2000 + 16'(e * 16), 0);
    #1 chk("R4", "short still fits", 32'(busy), 0);
    @(negedge clk); long_mode = 1'b1;
    #1 chk("R4", "long no longer fits", 32'(busy), 1);
    @(negedge clk); long_mode = 1'b0;
    #1 chk("R4", "busy latched after mode back", 32'(busy), 1);
    @(negedge clk); trig = 1'b1;
    #1 chk("R5", "trigger vetoed while latched", 32'(busy), 1);
    @(negedge clk); trig = 1'b0;
    #1 chk("R5", "still six events", 32'(evt_count), 6);
    drain_all(2);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); long_mode = 1'b0;
    for (int i = 0; i < 2 * LS; i++) begin
      @(negedge clk);
      trig = 1'b1; din = 16'h500 + 16'(i);
      exp_q.push_back({(i % LS) == LS - 1, 16'h500 + 16'(i)});
    end
    @(negedge clk); trig = 1'b0;
    #1;
    chk("R1", "back to back events", 32'(evt_count), 2);
    chk("R3", "overlaps during held trigger", 32'(ovl_cnt), 32'(1 + 2 * (LS - 1)));
    for (int e = 2; e < CAP; e++) send_event(1'b0, 16'h600 + 16'(e * 16), 0);
    #1 chk("R4", "full again", 32'(busy), 1);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); trig = 1'b1;
    end
    @(negedge clk); trig = 1'b0;
    #1 chk("R9", "veto saturates", 32'(veto_cnt), 15);
    drain_all(4);
    chk("R9", "veto kept after drain", 32'(veto_cnt), 15);
    chk("R9", "ovl kept after drain", 32'(ovl_cnt), 32'(1 + 2 * (LS - 1)));
    send_event(1'b0, 16'h7000, 0);
    #1 chk("R8", "re-armed after drain", 32'(evt_count), 1);
    send_event(1'b0, 16'h7100, 0);
    for (int e = 2; e < CAP; e++) send_event(1'b0, 16'h7200 + 16'(e * 16), 0);
    drain_all(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fill_short();
    t_long();
    t_mode_switch();
    t_back_to_back();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule